// File: doc/BRIEF.md
# On-chip Data Memory Access Router

This block sits between a small 8-bit processor core and the data storage around it. Each access from the core carries a kind, an address, write data and a write flag. The block decodes it and sends it to one of five places: the lower half of the core RAM, the upper half of the core RAM, a 256-byte auxiliary RAM, the special-function-register space, or an external memory bus. Both RAMs are held inside the block. Reads from on-chip targets come back one cycle later.

The low 256 bytes of the external-move address space are served by the auxiliary RAM, and the pins do not move during those accesses. An external-move through the 16-bit pointer reaches the external bus only when its address is above 255. A bus cycle has an address-latch phase followed by a strobe phase. The low address byte and the data share one port, and the high address byte has a port of its own. The core waits on `busy`, and a one-cycle `ext_done` pulse ends the bus cycle.

Top module: `dmem_router`

## Requirements
- R1: Kind 0 (direct) with address bits [7:0] below 0x80 selects the lower core RAM. Kind 1 (register-indirect) with bits [7:0] below 0x80 selects the same bytes. Address bits above bit 7 are ignored for kinds 0 and 1.
- R2: Kind 1 with bits [7:0] of 0x80 or above selects the upper core RAM and asserts `sel_hi`.
- R3: Kind 0 with bits [7:0] of 0x80 or above asserts `sfr_sel` (and `sfr_write` for writes). A read returns `sfr_rdata`. The upper core RAM is not written.
- R4: Kind 2 (byte-pointer external move) always selects the auxiliary RAM at address bits [7:0], whatever the high byte holds. It never starts an external bus cycle.
- R5: Kind 3 (word-pointer external move) with an address below 0x100 selects the auxiliary RAM and reaches the same bytes as kind 2.
- R6: An auxiliary RAM access leaves `ext_ad_o`, `ext_ad_oe` and `ext_hi` unchanged. It also keeps `ext_ale` low and both strobes high.
- R7: Kind 3 with an address of 0x100 or above runs a bus cycle. In the first cycle `ext_ale` is 1, `ext_ad_o` holds address bits [7:0], `ext_hi` holds the upper bits and `ext_ad_oe` is 1. Then `ext_wr_n` or `ext_rd_n` is low for STRB_CYC cycles, and the two strobes are never low together. A write drives the write data with `ext_ad_oe` at 1. A read releases the port (`ext_ad_oe` at 0).
- R8: In the cycle after the strobe ends, `ext_done` pulses for one cycle. For a read, `rsp_valid` is 1 in that same cycle, and `rsp_rdata` holds `ext_ad_i` as sampled in the last strobe cycle. `busy` is 1 from the address phase to the end of the strobe, and requests made while busy are ignored.
- R9: An accepted on-chip read (lower, upper, auxiliary or register space) gives `rsp_valid` = 1 with its data in the cycle after acceptance. Writes give no `rsp_valid`.
- R10: While reset is held, `ext_ale`, `ext_ad_oe`, `ext_done`, `busy` and `rsp_valid` are 0. Both strobes are 1, and `ext_ad_o` and `ext_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request |
| req_kind | input | 2 | 0 direct, 1 indirect, 2 byte-pointer move, 3 word-pointer move |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | External cycle in progress; requests ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data to the core |
| ext_done | output | 1 | External cycle finished |
| sel_lo | output | 1 | Lower core RAM selected |
| sel_hi | output | 1 | Upper core RAM selected |
| sel_aux | output | 1 | Auxiliary RAM selected |
| sfr_sel | output | 1 | Register space selected |
| sfr_write | output | 1 | Register space write |
| sfr_rdata | input | 8 | Register space read data |
| ext_ad_o | output | 8 | Multiplexed low address / data out |
| ext_ad_oe | output | 1 | Drive enable for the address/data port |
| ext_ad_i | input | 8 | Data in from the address/data port |
| ext_hi | output | 8 | High address byte |
| ext_ale | output | 1 | Address latch enable |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_rd_n | output | 1 | Read strobe, active low |

## Verification
The bench probes the edges of the address map. It uses a direct access at 0x90, which a decoder that ignored the kind would write into the upper RAM, so a later indirect read would show the corrupted byte. It uses an external move at 0x00FF and at a byte-pointer address with a nonzero high byte, which a decoder testing only the full address would send to the bus. It uses a word-pointer move just above 255. It tracks the pins across auxiliary accesses that follow a bus cycle, so a port driven during those accesses shows up as a changed value. It also writes to the lower RAM while the bus is busy; a router that accepted that request would return the new byte later instead of the old one.

// File: rtl/dmem_router_pkg.sv
package dmem_router_pkg;

   typedef enum logic [1:0] {
      KIND_DIRECT   = 2'd0,
      KIND_INDIRECT = 2'd1,
      KIND_XBYTE    = 2'd2,
      KIND_XWORD    = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_LO   = 3'd1,
      TGT_HI   = 3'd2,
      TGT_AUX  = 3'd3,
      TGT_SFR  = 3'd4,
      TGT_EXT  = 3'd5
   } tgt_e;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
   import dmem_router_pkg::*;
#(
   parameter int AW      = 16,
   parameter int CORE_AW = 8
) (
   input  logic          acc_en,
   input  acc_kind_e     kind,
   input  logic [AW-1:0] addr,
   output tgt_e          tgt
);
   logic upper_half;
   logic above_core;

   assign upper_half = addr[CORE_AW-1];
   assign above_core = |addr[AW-1:CORE_AW];

   always_comb begin
      tgt = TGT_NONE;
      if (acc_en) begin
         unique case (kind)
            KIND_DIRECT:   tgt = upper_half ? TGT_SFR : TGT_LO;
            KIND_INDIRECT: tgt = upper_half ? TGT_HI  : TGT_LO;
            KIND_XBYTE:    tgt = TGT_AUX;
            KIND_XWORD:    tgt = above_core ? TGT_EXT : TGT_AUX;
            default:       tgt = TGT_NONE;
         endcase
      end
   end
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
   parameter int DW   = 8,
   parameter int BAW  = 8
) (
   input  logic           clk,
   input  logic           en,
   input  logic           we,
   input  logic [BAW-1:0] addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata
);
   localparam int DEPTH = 1 << BAW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/dmem_xbus.sv
module dmem_xbus #(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int CORE_AW  = 8,
   parameter int STRB_CYC = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  start_wr,
   input  logic [AW-1:0]         start_addr,
   input  logic [DW-1:0]         start_wdata,
   input  logic [DW-1:0]         ext_ad_i,
   output logic [DW-1:0]         ext_ad_o,
   output logic                  ext_ad_oe,
   output logic [AW-CORE_AW-1:0] ext_hi,
   output logic                  ext_ale,
   output logic                  ext_wr_n,
   output logic                  ext_rd_n,
   output logic                  busy,
   output logic                  done,
   output logic                  done_rd,
   output logic [DW-1:0]         rd_data
);
   localparam int CNT_W = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRB_CYC - 1);

   typedef enum logic [1:0] {XS_IDLE, XS_ALE, XS_DATA} xs_e;

   xs_e              state;
   logic [CNT_W-1:0] cnt;
   logic             is_wr;
   logic [DW-1:0]    wdata_q;

   assign busy = (state != XS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= XS_IDLE;
         cnt       <= '0;
         is_wr     <= 1'b0;
         wdata_q   <= '0;
         ext_ad_o  <= '0;
         ext_ad_oe <= 1'b0;
         ext_hi    <= '0;
         ext_ale   <= 1'b0;
         ext_wr_n  <= 1'b1;
         ext_rd_n  <= 1'b1;
         done      <= 1'b0;
         done_rd   <= 1'b0;
         rd_data   <= '0;
      end else begin
         done    <= 1'b0;
         done_rd <= 1'b0;
         unique case (state)
            XS_IDLE: begin
               if (start) begin
                  state     <= XS_ALE;
                  is_wr     <= start_wr;
                  wdata_q   <= start_wdata;
                  ext_ale   <= 1'b1;
                  ext_ad_o  <= start_addr[CORE_AW-1:0];
                  ext_hi    <= start_addr[AW-1:CORE_AW];
                  ext_ad_oe <= 1'b1;
               end
            end
            XS_ALE: begin
               state     <= XS_DATA;
               cnt       <= CNT_LOAD;
               ext_ale   <= 1'b0;
               ext_wr_n  <= ~is_wr;
               ext_rd_n  <= is_wr;
               ext_ad_oe <= is_wr;
               if (is_wr) ext_ad_o <= wdata_q;
            end
            XS_DATA: begin
               if (cnt == '0) begin
                  state     <= XS_IDLE;
                  ext_wr_n  <= 1'b1;
                  ext_rd_n  <= 1'b1;
                  ext_ad_oe <= 1'b0;
                  done      <= 1'b1;
                  done_rd   <= ~is_wr;
                  if (!is_wr) rd_data <= ext_ad_i;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= XS_IDLE;
         endcase
      end
   end

   a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ext_wr_n && !ext_rd_n));

   a_r7_ale_leads_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ext_ale) |-> (!ext_wr_n || !ext_rd_n));

   a_r7_read_releases_port: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n |-> !ext_ad_oe);

   a_r8_done_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ext_wr_n && ext_rd_n && ($rose(ext_wr_n) || $rose(ext_rd_n))));

   a_r8_busy_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_wr_n || !ext_rd_n || ext_ale) |-> busy);
endmodule

// File: rtl/dmem_router.sv
module dmem_router
   import dmem_router_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int CORE_AW  = 8,
   parameter int STRB_CYC = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [1:0]            req_kind,
   input  logic [AW-1:0]         req_addr,
   input  logic                  req_write,
   input  logic [DW-1:0]         req_wdata,
   output logic                  busy,
   output logic                  rsp_valid,
   output logic [DW-1:0]         rsp_rdata,
   output logic                  ext_done,
   output logic                  sel_lo,
   output logic                  sel_hi,
   output logic                  sel_aux,
   output logic                  sfr_sel,
   output logic                  sfr_write,
   input  logic [DW-1:0]         sfr_rdata,
   output logic [DW-1:0]         ext_ad_o,
   output logic                  ext_ad_oe,
   input  logic [DW-1:0]         ext_ad_i,
   output logic [AW-CORE_AW-1:0] ext_hi,
   output logic                  ext_ale,
   output logic                  ext_wr_n,
   output logic                  ext_rd_n
);
   if (DW < 1) begin : g_bad_dw
      $error("dmem_router: DW must be at least 1");
   end
   if (CORE_AW < 2) begin : g_bad_core
      $error("dmem_router: CORE_AW must be at least 2");
   end
   if (AW <= CORE_AW) begin : g_bad_aw
      $error("dmem_router: AW must exceed CORE_AW");
   end
   if (STRB_CYC < 1) begin : g_bad_strb
      $error("dmem_router: STRB_CYC must be at least 1");
   end

   tgt_e          tgt;
   tgt_e          rsp_src;
   logic          accept;
   logic          ext_start;
   logic [DW-1:0] core_q;
   logic [DW-1:0] aux_q;
   logic [DW-1:0] sfr_q;
   logic [DW-1:0] x_rdata;
   logic          x_done_rd;

   assign accept = req_valid && !busy;

   dmem_decode #(.AW(AW), .CORE_AW(CORE_AW)) u_decode (
      .acc_en (accept),
      .kind   (acc_kind_e'(req_kind)),
      .addr   (req_addr),
      .tgt    (tgt)
   );

   assign sel_lo    = (tgt == TGT_LO);
   assign sel_hi    = (tgt == TGT_HI);
   assign sel_aux   = (tgt == TGT_AUX);
   assign sfr_sel   = (tgt == TGT_SFR);
   assign sfr_write = sfr_sel && req_write;
   assign ext_start = (tgt == TGT_EXT);

   dmem_bank #(.DW(DW), .BAW(CORE_AW)) u_core_ram (
      .clk   (clk),
      .en    (sel_lo || sel_hi),
      .we    (req_write),
      .addr  (req_addr[CORE_AW-1:0]),
      .wdata (req_wdata),
      .rdata (core_q)
   );

   dmem_bank #(.DW(DW), .BAW(CORE_AW)) u_aux_ram (
      .clk   (clk),
      .en    (sel_aux),
      .we    (req_write),
      .addr  (req_addr[CORE_AW-1:0]),
      .wdata (req_wdata),
      .rdata (aux_q)
   );

   dmem_xbus #(.AW(AW), .DW(DW), .CORE_AW(CORE_AW), .STRB_CYC(STRB_CYC)) u_xbus (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (ext_start),
      .start_wr    (req_write),
      .start_addr  (req_addr),
      .start_wdata (req_wdata),
      .ext_ad_i    (ext_ad_i),
      .ext_ad_o    (ext_ad_o),
      .ext_ad_oe   (ext_ad_oe),
      .ext_hi      (ext_hi),
      .ext_ale     (ext_ale),
      .ext_wr_n    (ext_wr_n),
      .ext_rd_n    (ext_rd_n),
      .busy        (busy),
      .done        (ext_done),
      .done_rd     (x_done_rd),
      .rd_data     (x_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_src <= TGT_NONE;
         sfr_q   <= '0;
      end else begin
         rsp_src <= (!req_write && tgt != TGT_EXT) ? tgt : TGT_NONE;
         if (sfr_sel) sfr_q <= sfr_rdata;
      end
   end

   always_comb begin
      unique case (rsp_src)
         TGT_LO, TGT_HI: rsp_rdata = core_q;
         TGT_AUX:        rsp_rdata = aux_q;
         TGT_SFR:        rsp_rdata = sfr_q;
         default:        rsp_rdata = x_rdata;
      endcase
   end

   assign rsp_valid = (rsp_src != TGT_NONE) || x_done_rd;

   a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_lo, sel_hi, sel_aux, sfr_sel, ext_start}));

   a_r3_sfr_spares_ram: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_sel |-> !(sel_hi || sel_lo));

   a_r4_byte_ptr_stays_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_kind == 2'd2) |-> (sel_aux && !ext_start));

   a_r6_aux_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sel_aux |=> ($stable(ext_ad_o) && $stable(ext_hi) && !ext_ad_oe &&
                   !ext_ale && ext_wr_n && ext_rd_n));

   a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |-> !(sel_lo || sel_hi || sel_aux || sfr_sel));

   a_r9_onchip_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_lo || sel_hi || sel_aux || sfr_sel) && !req_write) |=> rsp_valid);
endmodule

// File: tb/dmem_router_tb.sv
module dmem_router_tb;
   localparam int STRB = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'd0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic [7:0]  sfr_rdata = 8'hC3;
   logic [7:0]  ext_ad_i = 8'h00;
   logic        busy, rsp_valid, ext_done, sel_lo, sel_hi, sel_aux, sfr_sel, sfr_write;
   logic        ext_ad_oe, ext_ale, ext_wr_n, ext_rd_n;
   logic [7:0]  rsp_rdata, ext_ad_o, ext_hi;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dmem_router #(.AW(16), .DW(8), .CORE_AW(8), .STRB_CYC(STRB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ext_done(ext_done),
      .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_aux(sel_aux), .sfr_sel(sfr_sel),
      .sfr_write(sfr_write), .sfr_rdata(sfr_rdata), .ext_ad_o(ext_ad_o),
      .ext_ad_oe(ext_ad_oe), .ext_ad_i(ext_ad_i), .ext_hi(ext_hi), .ext_ale(ext_ale),
      .ext_wr_n(ext_wr_n), .ext_rd_n(ext_rd_n)
   );

   // {kind[38:37], write[36], addr[35:20], wdata[19:12], sel{lo,hi,aux,sfr}[11:8], rdata[7:0]}
   localparam int NVEC = 13;
   localparam logic [38:0] VEC [NVEC] = '{
      {2'd0, 1'b1, 16'h0012, 8'hA1, 4'b1000, 8'h00},  // R1 direct write low
      {2'd1, 1'b0, 16'h0012, 8'h00, 4'b1000, 8'hA1},  // R1 indirect read same byte
      {2'd1, 1'b1, 16'h0090, 8'hB2, 4'b0100, 8'h00},  // R2 indirect write upper
      {2'd0, 1'b0, 16'h0090, 8'h00, 4'b0001, 8'hC3},  // R3 direct read goes to SFR
      {2'd0, 1'b1, 16'h0090, 8'h55, 4'b0001, 8'h00},  // R3 direct write goes to SFR
      {2'd1, 1'b0, 16'h0090, 8'h00, 4'b0100, 8'hB2},  // R3 upper RAM untouched
      {2'd2, 1'b1, 16'h7734, 8'hC4, 4'b0010, 8'h00},  // R4 byte ptr, high byte ignored
      {2'd3, 1'b0, 16'h0034, 8'h00, 4'b0010, 8'hC4},  // R5 word ptr low reads aux
      {2'd3, 1'b1, 16'h00FF, 8'hD5, 4'b0010, 8'h00},  // R5 word ptr at 0x00FF
      {2'd2, 1'b0, 16'hABFF, 8'h00, 4'b0010, 8'hD5},  // R4 byte ptr read back
      {2'd0, 1'b0, 16'hFF12, 8'h00, 4'b1000, 8'hA1},  // R1 upper address bits ignored
      {2'd1, 1'b1, 16'h0034, 8'h11, 4'b1000, 8'h00},  // R1 core byte 0x34
      {2'd2, 1'b0, 16'h0034, 8'h00, 4'b0010, 8'hC4}   // R4 aux separate from core
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic onchip(input logic [1:0] k, input logic w, input logic [15:0] a,
                         input logic [7:0] d, input logic [3:0] esel, input logic [7:0] erd,
                         input string tag);
      logic [7:0] ad0, hi0;
      logic       oe0;
      ad0 = ext_ad_o; hi0 = ext_hi; oe0 = ext_ad_oe;
      req_kind = k; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      #1;
      chk({sel_lo, sel_hi, sel_aux, sfr_sel} == esel, {tag, " select"},
          {sel_lo, sel_hi, sel_aux, sfr_sel}, esel);
      chk(sfr_write == (esel[0] && w), {tag, " sfr_write"}, sfr_write, esel[0] && w);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == !w, {tag, " rsp_valid"}, rsp_valid, !w);
      if (!w) chk(rsp_rdata == erd, {tag, " rdata"}, rsp_rdata, erd);
      if (esel[1])
         chk(ext_ad_o == ad0 && ext_hi == hi0 && ext_ad_oe == oe0 && !ext_ale &&
             ext_wr_n && ext_rd_n && !busy, "R6 aux pins quiet",
             {ext_ad_o, ext_hi, 5'd0, ext_ad_oe, ext_wr_n, ext_rd_n},
             {ad0, hi0, 5'd0, oe0, 2'b11});
   endtask

   task automatic ext_cycle(input logic w, input logic [15:0] a, input logic [7:0] d,
                            input logic [7:0] pin, input bit inject);
      ext_ad_i = pin;
      req_kind = 2'd3; req_write = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
      @(negedge clk);
      chk(ext_ale && ext_ad_oe && busy, "R7 address phase", {ext_ale, ext_ad_oe, busy}, 3'b111);
      chk(ext_ad_o == a[7:0] && ext_hi == a[15:8], "R7 address bytes", {ext_hi, ext_ad_o}, a);
      if (inject) begin
         req_kind = 2'd0; req_write = 1'b1; req_addr = 16'h0020; req_wdata = 8'hEE;
         #1;
         chk(!sel_lo, "R8 request ignored while busy", sel_lo, 1'b0);
      end else begin
         req_valid = 1'b0;
      end
      @(negedge clk);
      req_valid = 1'b0;
      chk(!ext_ale && ext_wr_n == !w && ext_rd_n == w, "R7 strobe phase",
          {ext_ale, ext_wr_n, ext_rd_n}, {1'b0, !w, w});
      chk(ext_ad_oe == w, "R7 port drive", ext_ad_oe, w);
      if (w) chk(ext_ad_o == d, "R7 write data", ext_ad_o, d);
      for (int i = 1; i < STRB; i++) begin
         @(negedge clk);
         chk(ext_wr_n == !w && ext_rd_n == w && busy, "R7 strobe length",
             {ext_wr_n, ext_rd_n, busy}, {!w, w, 1'b1});
      end
      @(negedge clk);
      chk(ext_done && ext_wr_n && ext_rd_n && !busy, "R8 done pulse",
          {ext_done, ext_wr_n, ext_rd_n, busy}, 4'b1110);
      chk(rsp_valid == !w, "R8 rsp_valid", rsp_valid, !w);
      if (!w) chk(rsp_rdata == pin, "R8 read data", rsp_rdata, pin);
      @(negedge clk);
      chk(!ext_done, "R8 done one cycle", ext_done, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!ext_ale && !ext_ad_oe && !ext_done && !busy && !rsp_valid && ext_wr_n && ext_rd_n,
          "R10 reset controls", {ext_ale, ext_ad_oe, ext_done, busy, rsp_valid, ext_wr_n, ext_rd_n},
          7'b0000011);
      chk(ext_ad_o == 8'h00 && ext_hi == 8'h00, "R10 reset ports", {ext_hi, ext_ad_o}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      onchip(2'd0, 1'b1, 16'h0020, 8'h77, 4'b1000, 8'h00, "R1 setup");
      ext_cycle(1'b1, 16'h1234, 8'h5A, 8'h00, 1'b0);   // R7 write
      ext_cycle(1'b0, 16'h8001, 8'h00, 8'h3C, 1'b1);   // R8 read, request injected
      ext_cycle(1'b0, 16'h0100, 8'h00, 8'h96, 1'b0);   // R7 lowest external address
      onchip(2'd0, 1'b0, 16'h0020, 8'h00, 4'b1000, 8'h77, "R8 ignored write left byte");

      for (int v = 0; v < NVEC; v++)
         onchip(VEC[v][38:37], VEC[v][36], VEC[v][35:20], VEC[v][19:12],
                VEC[v][11:8], VEC[v][7:0], $sformatf("R9 vector %0d", v));

      // R9 SFR read data follows the sampled input
      sfr_rdata = 8'h4E;
      onchip(2'd0, 1'b0, 16'h00FE, 8'h00, 4'b0001, 8'h4E, "R3 sfr read");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule